// File: doc/BRIEF.md
# Serial Response Receiver

This block collects a reply frame from a remote target over a two-wire link: a serial clock that the block drives, and a data line that the target drives while the block listens. A controller pulses `start` with the number of payload bytes it expects. The block then toggles the serial clock, one bit per period, until the target pulls the line low to mark the start of a frame. If that start marker does not come within a fixed number of clocks, the block gives up and reports a timeout.

After the start marker the block reads a 4-bit header. The header carries a 2-bit target identifier and a 2-bit response tag. Payload bytes follow only when the tag is an acknowledge and the expected size is nonzero, so the frame length depends on what is received. The frame ends with a 4-bit check code. The data line is active-low, so each sampled level is inverted before use. The line passes through a two-flop synchronizer and is sampled on the system edge just before the serial clock rises.

When the frame ends, the block raises `done` for one cycle and reports one result. A frame with a good check code returns its tag as the result. A frame with a bad check code reports bad CRC, unless every bit after the start marker was logical 0 (the line never left its idle high level). In that case it reports no device.

Top module: `resp_rx`

## Requirements
- R1: After reset and whenever idle, `scl_out` is 1 and `busy` and `done` are 0.
- R2: Each serial bit period is HALF system cycles with `scl_out` low, then HALF cycles high. The line value is taken on the last low cycle, through a two-flop synchronizer.
- R3: The data line is active-low: a sampled line level of 0 is logical 1. The start marker is the first logical 1.
- R4: If no start marker arrives within TIMEOUT_CLKS serial clocks, the result is 4 (timeout) and `tag`, `slave_id` and `data_out` are 0.
- R5: The 4 header bits that follow the start marker are, in arrival order, `slave_id` bit 1, `slave_id` bit 0, `tag` bit 1 and `tag` bit 0. Tag codes: 0 acknowledge, 1 busy, 2 address error, 3 command CRC error.
- R6: `size_bytes` is latched when `start` is accepted, and `start` has no effect while `busy` is 1. Exactly 8×size payload bits are read, and only when the tag is 0 and the size is nonzero. Otherwise the 4 check bits follow the header directly.
- R7: The check code uses x^4+x+1, most significant bit first, starting from zero. It runs over the start marker, the header, the payload and the 4 received check bits. A zero remainder gives a result equal to the tag (0..3).
- R8: A nonzero remainder gives result 6 (bad CRC). If every logical bit after the start marker was 0, it gives result 5 (no device) instead.
- R9: `data_out` holds the payload right-aligned, with the first received byte most significant and unused upper bits 0. It is all zero unless the result is 0.
- R10: `done` is a one-cycle pulse on the cycle `busy` falls. It comes HALF + (N−1)·2·HALF cycles after the edge that accepts `start`, where N is the number of serial clocks used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin receiving a frame (accepted while idle) |
| size_bytes | input | $clog2(MAX_BYTES+1) | Expected payload bytes, 0..MAX_BYTES |
| sda_in | input | 1 | Raw data line from the target, active-low |
| scl_out | output | 1 | Serial clock to the target, idle high |
| busy | output | 1 | Receive in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0..3 tag, 4 timeout, 5 no device, 6 bad CRC |
| slave_id | output | 2 | Received target identifier |
| tag | output | 2 | Received response tag |
| data_out | output | 8*MAX_BYTES | Received payload |

## Verification
The in-RTL assertions check the following on every cycle:
- `done` is a single pulse that only occurs while idle.
- The serial clock stays low for at least two cycles.
- The latched size is stable during a transfer.
- A good-code result matches the reported tag.
- Payload is zero on non-acknowledge results.

Only the bench scenarios can show the rest:
- Tag-dependent frame length.
- Check-code arithmetic.
- The split between no device and bad CRC.
- The timeout boundary at the last allowed clock.
- The exact completion latency against an independent behavioural model of the frame.

// File: rtl/resp_rx.sv
module resp_rx #(
  parameter int HALF         = 4,
  parameter int TIMEOUT_CLKS = 16,
  parameter int MAX_BYTES    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [$clog2(MAX_BYTES+1)-1:0]     size_bytes,
  input  logic                               sda_in,
  output logic                               scl_out,
  output logic                               busy,
  output logic                               done,
  output logic [2:0]                         result,
  output logic [1:0]                         slave_id,
  output logic [1:0]                         tag,
  output logic [8*MAX_BYTES-1:0]             data_out
);
  localparam int SW = $clog2(MAX_BYTES+1);
  localparam int DW = 8*MAX_BYTES;
  localparam int PW = $clog2(2*HALF);
  localparam int CW = $clog2(DW) + 1;
  localparam int TW = $clog2(TIMEOUT_CLKS+1);
  localparam logic [2:0] RES_TIMEOUT = 3'd4;
  localparam logic [2:0] RES_NODEV   = 3'd5;
  localparam logic [2:0] RES_BADCRC  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_HDR, S_DATA, S_CRC} st_t;

  st_t            st;
  logic [PW-1:0]  ph;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  hunt;
  logic           s1, s2;
  logic [3:0]     crc, hdr;
  logic [DW-1:0]  shreg;
  logic           anyone;
  logic [SW-1:0]  size_q;

  wire       smp       = (st != S_IDLE) && (ph == PW'(HALF-1));
  wire       bit_in    = ~s2;
  wire [3:0] crc_nx    = {crc[2:0], 1'b0} ^ (((crc[3] ^ bit_in) != 1'b0) ? 4'b0011 : 4'b0000);
  wire [1:0] tag_nx    = {hdr[0], bit_in};
  wire       data_last = cnt == ((CW'(size_q) << 3) - CW'(1));
  wire       any_nx    = anyone | bit_in;
  wire       crc_ok    = crc_nx == 4'd0;

  assign busy    = st != S_IDLE;
  assign scl_out = !(busy && ph < PW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= sda_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      cnt      <= '0;
      hunt     <= '0;
      crc      <= '0;
      hdr      <= '0;
      shreg    <= '0;
      anyone   <= 1'b0;
      size_q   <= '0;
      done     <= 1'b0;
      result   <= '0;
      slave_id <= '0;
      tag      <= '0;
      data_out <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        ph <= '0;
        if (start) begin
          st     <= S_HUNT;
          cnt    <= '0;
          hunt   <= '0;
          crc    <= '0;
          hdr    <= '0;
          shreg  <= '0;
          anyone <= 1'b0;
          size_q <= size_bytes;
        end
      end else begin
        ph <= (ph == PW'(2*HALF-1)) ? '0 : ph + PW'(1);
        if (smp) begin
          case (st)
            S_HUNT: begin
              if (bit_in) begin
                st  <= S_HDR;
                crc <= crc_nx;
              end else if (hunt == TW'(TIMEOUT_CLKS-1)) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                result   <= RES_TIMEOUT;
                tag      <= '0;
                slave_id <= '0;
                data_out <= '0;
              end else begin
                hunt <= hunt + TW'(1);
              end
            end
            S_HDR: begin
              hdr    <= {hdr[2:0], bit_in};
              crc    <= crc_nx;
              anyone <= any_nx;
              if (cnt == CW'(3)) begin
                cnt <= '0;
                st  <= (tag_nx == 2'd0 && size_q != '0) ? S_DATA : S_CRC;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
            S_DATA: begin
              shreg  <= {shreg[DW-2:0], bit_in};
              crc    <= crc_nx;
              anyone <= any_nx;
              if (data_last) begin
                cnt <= '0;
                st  <= S_CRC;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
            S_CRC: begin
              crc    <= crc_nx;
              anyone <= any_nx;
              if (cnt == CW'(3)) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                tag      <= hdr[1:0];
                slave_id <= hdr[3:2];
                result   <= crc_ok ? {1'b0, hdr[1:0]} : (any_nx ? RES_BADCRC : RES_NODEV);
                data_out <= (crc_ok && hdr[1:0] == 2'd0) ? shreg : '0;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_out) |=> !scl_out);
  // R6
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(size_q));
  // R7
  tag_result_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && result < 3'd4) |-> result[1:0] == tag);
  // R9
  data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && result != 3'd0) |-> data_out == '0);
endmodule

// File: tb/test_resp_rx.sv
module test_resp_rx;
  localparam int HALF = 4, TMO = 16, MB = 4;

  logic clk = 0, rst_n = 0, start = 0, sda = 1;
  logic [2:0] size_bytes = '0;
  logic scl, busy, done;
  logic [2:0] result;
  logic [1:0] slave_id, tag;
  logic [31:0] data_out;

  int checks = 0, errors = 0, cyc = 0;
  bit line_q[$];
  bit frm[$];
  bit scl_prev = 1, running = 0;
  int falls = 0;

  resp_rx #(.HALF(HALF), .TIMEOUT_CLKS(TMO), .MAX_BYTES(MB)) i_resp_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .size_bytes(size_bytes), .sda_in(sda),
    .scl_out(scl), .busy(busy), .done(done), .result(result), .slave_id(slave_id),
    .tag(tag), .data_out(data_out));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!scl && scl_prev) begin
        falls++;
        sda = (line_q.size() > 0) ? line_q.pop_front() : 1'b1;
      end
      scl_prev = scl;
      chk(busy == running, "R10", "busy vs model", busy, running);
      if (!running) chk(scl == 1'b1, "R1", "idle clock level", scl, 1);
    end
  end

  function automatic logic [3:0] c4(input logic [3:0] c, input bit b);
    return {c[2:0], 1'b0} ^ ((c[3] ^ b) ? 4'h3 : 4'h0);
  endfunction

  task automatic build(input int id, input int tg, input int nbytes, input logic [31:0] d, input logic [3:0] corrupt);
    logic [3:0] c = c4(4'h0, 1'b1);
    frm.delete();
    for (int i = 1; i >= 0; i--) frm.push_back(id[i]);
    for (int i = 1; i >= 0; i--) frm.push_back(tg[i]);
    if (tg == 0) for (int i = nbytes*8-1; i >= 0; i--) frm.push_back(d[i]);
    foreach (frm[i]) c = c4(c, frm[i]);
    c ^= corrupt;
    for (int i = 3; i >= 0; i--) frm.push_back(c[i]);
  endtask

  task automatic run(input string name, input int pre, input int sz, input bit poke);
    int e_res, e_bits, e_tag = 0, e_id = 0, idx = 0, n, wd = 0, c0;
    logic [31:0] e_data = 0;
    logic [3:0] c;
    bit anyb = 0, b;
    if (pre >= TMO) begin
      e_res = 4; e_bits = TMO;
    end else begin
      c = c4(4'h0, 1'b1);
      for (int i = 0; i < 4; i++) begin
        b = (idx < frm.size()) ? frm[idx] : 1'b0; idx++;
        c = c4(c, b); anyb |= b;
        if (i < 2) e_id = e_id*2 + b; else e_tag = e_tag*2 + b;
      end
      n = (e_tag == 0 && sz != 0) ? sz*8 : 0;
      for (int i = 0; i < n; i++) begin
        b = (idx < frm.size()) ? frm[idx] : 1'b0; idx++;
        c = c4(c, b); anyb |= b; e_data = {e_data[30:0], b};
      end
      for (int i = 0; i < 4; i++) begin
        b = (idx < frm.size()) ? frm[idx] : 1'b0; idx++;
        c = c4(c, b); anyb |= b;
      end
      e_res = (c == 0) ? e_tag : (anyb ? 6 : 5);
      if (e_res != 0) e_data = 0;
      e_bits = pre + 1 + 4 + n + 4;
    end
    line_q.delete();
    for (int i = 0; i < pre; i++) line_q.push_back(1'b1);
    if (pre < TMO) begin
      line_q.push_back(1'b0);
      foreach (frm[i]) line_q.push_back(~frm[i]);
    end
    falls = 0;
    @(negedge clk); start = 1; size_bytes = 3'(sz);
    @(posedge clk); c0 = cyc + 1; running = 1;
    @(negedge clk); start = 0;
    while (!done && wd < 5000) begin
      @(negedge clk); wd++;
      if (poke && wd == 20) begin start = 1; size_bytes = 3'd1; end
      if (poke && wd == 21) start = 0;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 %s watchdog: actual no done expected done", name);
      running = 0;
      return;
    end
    running = 0;
    chk(result == 3'(e_res), (e_res == 4) ? "R4" : (e_res >= 5 ? "R8" : "R7"), {name, " result"}, result, e_res);
    chk(data_out == e_data, "R9", {name, " data"}, data_out, e_data);
    if (e_res < 4) begin
      chk(tag == 2'(e_tag), "R5", {name, " tag"}, tag, e_tag);
      chk(slave_id == 2'(e_id), "R5", {name, " id"}, slave_id, e_id);
    end
    chk(falls == e_bits, "R6", {name, " clocks used"}, falls, e_bits);
    chk(cyc - c0 == HALF + (e_bits-1)*2*HALF, "R10", {name, " latency"}, cyc - c0, HALF + (e_bits-1)*2*HALF);
    @(negedge clk);
    chk(!done, "R10", {name, " done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl == 1 && !busy && !done, "R1", "reset outputs", {scl, busy, done}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    build(2, 0, 4, 32'hDEADBEEF, 0); run("ack4 R3", 3, 4, 0);
    build(1, 0, 1, 32'h5A, 0);        run("ack1", 0, 1, 0);
    build(3, 0, 0, 0, 0);             run("ack0 R6", 2, 0, 0);
    build(0, 1, 4, 0, 0);             run("busy R5", 1, 4, 0);
    build(2, 2, 4, 0, 0);             run("addr", 0, 2, 0);
    build(1, 3, 4, 0, 0);             run("cmdcrc", 0, 2, 0);
    build(1, 0, 2, 32'h1234, 4'h4);   run("badcrc R8", 1, 2, 0);
    frm.delete();                     run("timeout R4", TMO, 2, 0);
    build(3, 0, 2, 32'hA5C3, 0);      run("late start R4", TMO-1, 2, 0);
    frm.delete();                     run("nodev R8", 0, 2, 0);
    build(2, 0, 4, 32'h0102_0304, 0); run("poke start R6", 1, 4, 1);
    build(0, 0, 2, 32'hBEEF, 0);      run("mask R9", 0, 2, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL R10 global watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule